// File: doc/BRIEF.md
# Privilege-Gated Security Control Register

This block holds the two security controls of a small processor core in a 16-bit control word. A loader lock bit decides whether the protected loader and debug routines need a successful 32-byte password comparison before they may run. A protection-enable bit decides whether memory protection is active and whether protection-fault interrupts can be raised. Each bit has its own reset behaviour and its own rule for which writers may change it.

Writes arrive on a simple strobe-plus-data port, together with the current privilege level and a flag that marks the writer as utility ROM code. A disallowed change to one bit is dropped silently, and any other bit in the same write still updates. The block also turns the register contents, the password comparison result and a word read from a fixed flash location into three permits: loader/debug access, ROM-assisted debug commands, and protection-fault generation. Utility ROM reads are always granted. The flash word comes from flash word address 000Eh. The flash array, the ROM and the fault handler are outside the block.

Privilege is encoded as 0 = low, 1 = medium, 2 = high, and 3 is treated as high. The asynchronous `rst_n` acts as a power-on reset. `sys_rst` is a synchronous reset request qualified by `rst_kind`: 0 = power-on, 1 = power-fail, 2 = watchdog, 3 = external.

Top module: `sec_ctrl_reg`

## Requirements
- R1: Asserting `rst_n` low sets the lock bit (bit 9) to 1. A `sys_rst` pulse with `rst_kind` 0 or 1 also sets the lock bit to 1 on the next clock edge.
- R2: `loader_grant` is 1 when the lock bit is 0. While the lock bit is 1, `loader_grant` follows `pwd_match`.
- R3: A write changes the lock bit to `wr_data[9]` only when `from_urom` is 1 and `priv` is 1 or higher. Any other write leaves the lock bit unchanged.
- R4: `dbg_cmd_ok` is 0 whenever `flash_word` differs from 16'hFFFF. When `flash_word` is 16'hFFFF, `dbg_cmd_ok` equals `loader_grant`.
- R5: A write can clear the protection bit (bit 10) from 1 to 0 only when `priv` is 2 or 3. A write can set the protection bit to 1 at any privilege level.
- R6: Every reset kind sets the protection bit to 1: `rst_n` low, and `sys_rst` with any `rst_kind`.
- R7: Every bit of `rd_data` other than bits 9 and 10 reads 0, including bits 15:11.
- R8: `fault_en` equals the protection bit, so no protection faults are enabled while that bit is 0.
- R9: A `sys_rst` pulse with `rst_kind` 2 or 3 leaves the lock bit unchanged.
- R10: `urom_rd_grant` equals `urom_rd_req`, whatever the protection bit holds.
- R11: Within one write, a permitted bit updates even when the other bit's change is refused. When `sys_rst` and `wr_en` are both high in the same cycle, the reset takes effect and the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| sys_rst | input | 1 | Synchronous reset request |
| rst_kind | input | 2 | Reset kind that qualifies `sys_rst` |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 16 | Write data |
| from_urom | input | 1 | The current writer is utility ROM code |
| priv | input | 2 | Current privilege level |
| pwd_match | input | 1 | The 32-byte password comparison succeeded |
| flash_word | input | 16 | Word read from the fixed flash location |
| urom_rd_req | input | 1 | Utility ROM read request |
| rd_data | output | 16 | Register read value |
| loader_grant | output | 1 | Protected loader/debug routines may run |
| dbg_cmd_ok | output | 1 | ROM-assisted debug commands are permitted |
| fault_en | output | 1 | Protection-fault interrupts are enabled |
| urom_rd_grant | output | 1 | Utility ROM read is granted |

## Verification
Writes to the lock bit are tried at every privilege level, with and without the ROM flag. This separates the ROM-origin condition from the privilege threshold. Writes to the protection bit are tried in both directions at medium and high privilege, which shows that the restriction applies to clearing only. Each reset kind is applied with the lock bit cleared beforehand, so a kind that should preserve the lock is distinguishable from one that should set it. The password result and the flash word are varied independently of the lock state, which shows that the flash veto overrides the lock/match outcome.

// File: rtl/sc_pkg.sv
package sc_pkg;

    typedef enum logic [1:0] {
        PRIV_LOW  = 2'd0,
        PRIV_MED  = 2'd1,
        PRIV_HIGH = 2'd2,
        PRIV_RSVD = 2'd3
    } priv_e;

    typedef enum logic [1:0] {
        RK_POWER_ON   = 2'd0,
        RK_POWER_FAIL = 2'd1,
        RK_WATCHDOG   = 2'd2,
        RK_EXTERNAL   = 2'd3
    } rst_kind_e;

    typedef struct packed {
        logic lock;
        logic prot;
    } sc_state_t;

    localparam sc_state_t SC_POR_STATE = '{lock: 1'b1, prot: 1'b1};

    function automatic logic priv_at_least(input logic [1:0] level, input priv_e floor);
        return level >= floor;
    endfunction

    function automatic logic kind_hits_lock(input logic [1:0] kind);
        return (kind == RK_POWER_ON) || (kind == RK_POWER_FAIL);
    endfunction

endpackage

// File: rtl/sc_write_rules.sv
module sc_write_rules
    import sc_pkg::*;
(
    input  sc_state_t   cur,
    input  logic        wr_en,
    input  logic        wr_lock,
    input  logic        wr_prot,
    input  logic        from_urom,
    input  logic [1:0]  priv,
    output sc_state_t   nxt
);
    logic lock_ok;
    logic prot_clear_ok;

    always_comb begin
        lock_ok       = from_urom && priv_at_least(priv, PRIV_MED);
        prot_clear_ok = priv_at_least(priv, PRIV_HIGH);
        nxt           = cur;
        if (wr_en) begin
            if (lock_ok) begin
                nxt.lock = wr_lock;
            end
            if (wr_prot) begin
                nxt.prot = 1'b1;
            end else if (prot_clear_ok) begin
                nxt.prot = 1'b0;
            end
        end
    end

endmodule

// File: rtl/sc_reset_rules.sv
module sc_reset_rules
    import sc_pkg::*;
(
    input  sc_state_t   cur,
    input  logic [1:0]  kind,
    output sc_state_t   nxt
);
    always_comb begin
        nxt      = cur;
        nxt.prot = 1'b1;
        if (kind_hits_lock(kind)) begin
            nxt.lock = 1'b1;
        end
    end

endmodule

// File: rtl/sc_access_gate.sv
module sc_access_gate #(
    parameter int          FW    = 16,
    parameter logic [FW-1:0] BLANK = '1
) (
    input  logic          lock,
    input  logic          prot,
    input  logic          pwd_match,
    input  logic [FW-1:0] flash_word,
    input  logic          urom_rd_req,
    output logic          loader_grant,
    output logic          dbg_cmd_ok,
    output logic          fault_en,
    output logic          urom_rd_grant
);
    logic flash_blank;

    always_comb begin
        flash_blank   = (flash_word == BLANK);
        loader_grant  = !lock || pwd_match;
        dbg_cmd_ok    = flash_blank && loader_grant;
        fault_en      = prot;
        urom_rd_grant = urom_rd_req;
    end

endmodule

// File: rtl/sec_ctrl_reg.sv
module sec_ctrl_reg
    import sc_pkg::*;
#(
    parameter int W        = 16,
    parameter int LOCK_BIT = 9,
    parameter int PROT_BIT = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sys_rst,
    input  logic [1:0]   rst_kind,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         from_urom,
    input  logic [1:0]   priv,
    input  logic         pwd_match,
    input  logic [W-1:0] flash_word,
    input  logic         urom_rd_req,
    output logic [W-1:0] rd_data,
    output logic         loader_grant,
    output logic         dbg_cmd_ok,
    output logic         fault_en,
    output logic         urom_rd_grant
);
    localparam logic [W-1:0] FLASH_BLANK = '1;

    sc_state_t state_q, state_d;
    sc_state_t wr_next, rst_next;
    logic      unused_wr_bits;

    assign unused_wr_bits = ^wr_data;

    sc_write_rules u_wr (
        .cur       (state_q),
        .wr_en     (wr_en),
        .wr_lock   (wr_data[LOCK_BIT]),
        .wr_prot   (wr_data[PROT_BIT]),
        .from_urom (from_urom),
        .priv      (priv),
        .nxt       (wr_next)
    );

    sc_reset_rules u_rst (
        .cur  (state_q),
        .kind (rst_kind),
        .nxt  (rst_next)
    );

    always_comb begin
        state_d = sys_rst ? rst_next : wr_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SC_POR_STATE;
        end else begin
            state_q <= state_d;
        end
    end

    for (genvar i = 0; i < W; i++) begin : g_rd
        if (i == LOCK_BIT) begin : g_lock
            assign rd_data[i] = state_q.lock;
        end else if (i == PROT_BIT) begin : g_prot
            assign rd_data[i] = state_q.prot;
        end else begin : g_zero
            assign rd_data[i] = 1'b0;
        end
    end

    sc_access_gate #(.FW(W), .BLANK(FLASH_BLANK)) u_gate (
        .lock          (state_q.lock),
        .prot          (state_q.prot),
        .pwd_match     (pwd_match),
        .flash_word    (flash_word),
        .urom_rd_req   (urom_rd_req),
        .loader_grant  (loader_grant),
        .dbg_cmd_ok    (dbg_cmd_ok),
        .fault_en      (fault_en),
        .urom_rd_grant (urom_rd_grant)
    );

endmodule

// File: rtl/sec_ctrl_reg_chk.sv
module sec_ctrl_reg_chk #(
    parameter int W        = 16,
    parameter int LOCK_BIT = 9,
    parameter int PROT_BIT = 10
) (
    input logic         clk,
    input logic         rst_n,
    input logic         sys_rst,
    input logic [1:0]   rst_kind,
    input logic         wr_en,
    input logic         from_urom,
    input logic [1:0]   priv,
    input logic [W-1:0] flash_word,
    input logic         urom_rd_req,
    input logic [W-1:0] rd_data,
    input logic         loader_grant,
    input logic         dbg_cmd_ok,
    input logic         urom_rd_grant
);
    localparam logic [W-1:0] LIVE_MASK = (W'(1) << LOCK_BIT) | (W'(1) << PROT_BIT);

    AST_SYS_RST_SETS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_rst && !rst_kind[1]) |=> rd_data[LOCK_BIT]); // R1
    AST_UNLOCKED_GRANTS: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data[LOCK_BIT] |-> loader_grant); // R2
    AST_LOCK_WRITE_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        (!sys_rst && !(wr_en && from_urom && priv != 2'd0)) |=> $stable(rd_data[LOCK_BIT])); // R3
    AST_FLASH_VETO: assert property (@(posedge clk) disable iff (!rst_n)
        (flash_word != '1) |-> !dbg_cmd_ok); // R4
    AST_PROT_NO_LOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (!sys_rst && !priv[1] && rd_data[PROT_BIT]) |=> rd_data[PROT_BIT]); // R5
    AST_RESET_SETS_PROT: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst |=> rd_data[PROT_BIT]); // R6
    AST_DEAD_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data & ~LIVE_MASK) == '0); // R7
    AST_WARM_RST_KEEPS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_rst && rst_kind[1]) |=> $stable(rd_data[LOCK_BIT])); // R9
    AST_UROM_READ_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        urom_rd_req |-> urom_rd_grant); // R10

endmodule

bind sec_ctrl_reg sec_ctrl_reg_chk #(.W(W), .LOCK_BIT(LOCK_BIT), .PROT_BIT(PROT_BIT)) u_chk (.*);

// File: tb/tb_sec_ctrl_reg.sv
module tb_sec_ctrl_reg;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sys_rst = 1'b0;
    logic [1:0]  rst_kind = 2'd0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        from_urom = 1'b0;
    logic [1:0]  priv = 2'd0;
    logic        pwd_match = 1'b0;
    logic [15:0] flash_word = 16'hFFFF;
    logic        urom_rd_req = 1'b0;
    logic [15:0] rd_data;
    logic        loader_grant, dbg_cmd_ok, fault_en, urom_rd_grant;

    always #10 clk = ~clk;

    sec_ctrl_reg dut (.*);

    typedef struct {
        logic [15:0] rd;
        logic        grant;
        logic        dbg;
        logic        fault;
        logic        rgrant;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;

    logic        m_lock, m_prot;
    logic        g_pm = 1'b0;
    logic [15:0] g_fw = 16'hFFFF;
    logic        g_rr = 1'b0;

    function automatic exp_t predict(input string tag);
        exp_t e;
        e.rd     = {5'b0, m_prot, m_lock, 9'b0};
        e.grant  = !m_lock || g_pm;
        e.dbg    = (g_fw == 16'hFFFF) && e.grant;
        e.fault  = m_prot;
        e.rgrant = g_rr;
        e.tag    = tag;
        return e;
    endfunction

    task automatic step(input logic wr, input logic [15:0] d, input logic [1:0] p,
                        input logic urom, input logic srst, input logic [1:0] kind,
                        input string tag);
        @(negedge clk);
        wr_en = wr; wr_data = d; priv = p; from_urom = urom;
        sys_rst = srst; rst_kind = kind;
        pwd_match = g_pm; flash_word = g_fw; urom_rd_req = g_rr;
        @(posedge clk);
        #2;
        if (srst) begin
            m_prot = 1'b1;
            if (kind <= 2'd1) m_lock = 1'b1;
        end else if (wr) begin
            if (urom && p >= 2'd1) m_lock = d[9];
            if (d[10]) m_prot = 1'b1;
            else if (p >= 2'd2) m_prot = 1'b0;
        end
        exp_q.push_back(predict(tag));
    endtask

    task automatic idle(input string tag);
        step(1'b0, 16'h0000, 2'd0, 1'b0, 1'b0, 2'd0, tag);
    endtask

    always @(posedge clk) begin
        #5;
        while (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_cmp++;
            if (rd_data !== e.rd || loader_grant !== e.grant || dbg_cmd_ok !== e.dbg ||
                fault_en !== e.fault || urom_rd_grant !== e.rgrant) begin
                n_bad++;
                $display("FAIL %s: actual rd=%h grant=%b dbg=%b fault=%b rg=%b expected rd=%h grant=%b dbg=%b fault=%b rg=%b",
                         e.tag, rd_data, loader_grant, dbg_cmd_ok, fault_en, urom_rd_grant,
                         e.rd, e.grant, e.dbg, e.fault, e.rgrant);
            end
        end
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        m_lock = 1'b1;
        m_prot = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        idle("R1 R6 R7 power-on state");
        g_pm = 1'b1;
        idle("R2 locked with match");
        g_pm = 1'b0;
        idle("R2 locked without match");

        step(1'b1, 16'h0000, 2'd0, 1'b1, 1'b0, 2'd0, "R3 lock write at low privilege ignored");
        step(1'b1, 16'h0000, 2'd2, 1'b0, 1'b0, 2'd0, "R3 lock write not from ROM ignored");
        step(1'b1, 16'h0400, 2'd1, 1'b1, 1'b0, 2'd0, "R3 lock cleared from ROM at medium");
        idle("R2 unlocked grants without match");

        g_fw = 16'h1234;
        idle("R4 programmed flash word vetoes debug");
        g_fw = 16'hFFFE;
        g_pm = 1'b1;
        idle("R4 veto with match");
        g_fw = 16'hFFFF;
        g_pm = 1'b0;
        idle("R4 blank flash word passes grant");

        step(1'b1, 16'h0000, 2'd1, 1'b1, 1'b0, 2'd0, "R5 protection clear at medium ignored");
        step(1'b1, 16'h0000, 2'd2, 1'b0, 1'b0, 2'd0, "R5 R8 protection cleared at high");
        g_rr = 1'b1;
        idle("R10 ROM read granted with protection off");
        step(1'b1, 16'h0400, 2'd0, 1'b0, 1'b0, 2'd0, "R5 protection set at low");
        idle("R10 ROM read granted with protection on");
        g_rr = 1'b0;

        step(1'b1, 16'h0000, 2'd3, 1'b1, 1'b0, 2'd0, "R5 R3 privilege 3 acts as high");
        step(1'b0, 16'h0000, 2'd0, 1'b0, 1'b1, 2'd2, "R9 R6 watchdog reset keeps lock");
        step(1'b1, 16'h0000, 2'd2, 1'b0, 1'b0, 2'd0, "R5 clear protection again");
        step(1'b0, 16'h0000, 2'd0, 1'b0, 1'b1, 2'd3, "R9 R6 external reset keeps lock");
        step(1'b0, 16'h0000, 2'd0, 1'b0, 1'b1, 2'd1, "R1 power-fail reset sets lock");

        step(1'b1, 16'h0000, 2'd1, 1'b1, 1'b0, 2'd0, "R11 lock updates while protection clear refused");
        step(1'b1, 16'hFFFF, 2'd2, 1'b1, 1'b0, 2'd0, "R7 all-ones write reads back only live bits");
        step(1'b1, 16'h0000, 2'd2, 1'b1, 1'b0, 2'd0, "R11 both bits cleared at high from ROM");
        step(1'b1, 16'h0000, 2'd2, 1'b1, 1'b1, 2'd0, "R11 R1 reset wins over same-cycle write");
        step(1'b1, 16'h0000, 2'd2, 1'b1, 1'b0, 2'd0, "R11 clear both before warm reset");
        step(1'b1, 16'h0000, 2'd2, 1'b1, 1'b1, 2'd2, "R11 R9 watchdog reset wins over write");

        @(negedge clk) rst_n = 1'b0;
        m_lock = 1'b1;
        m_prot = 1'b1;
        #1;
        n_cmp++;
        if (rd_data !== 16'h0600) begin
            n_bad++;
            $display("FAIL R1 R6 async reset: actual rd=%h expected rd=0600", rd_data);
        end
        @(negedge clk) rst_n = 1'b1;
        idle("R1 R6 state after async reset");

        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule